// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block drives the two active-low DMA request pins of a UART whose receive and transmit FIFOs hold 32 characters each. It does not touch the FIFOs. It watches four things: their fill levels, the receive trigger-level flag, the receive idle-timeout flag, and two bits of the FIFO control register. The two bits are the FIFO enable and the burst-mode select. From these it decides when a DMA controller should move data.

The block has two handshake styles.

- **Single-transfer (mode 0).** Each request simply mirrors whether data is available or space is free, so the controller moves one character per request.
- **Burst (mode 1).** Each request latches. The receive request is raised by the trigger level or by a timeout, and it is held until the receive FIFO is empty. The transmit request is raised when the transmit FIFO is empty, and it is held until the FIFO is full.

Burst mode is only reachable with the FIFOs enabled. With the FIFOs disabled (the single-holding-register compatibility mode), the block always uses single-transfer behaviour.

There is no data stream through this block. All pins are plain level signals, so no valid/ready back-pressure applies. Both outputs are registered.

Top module: `uart_dma_ready`

## Requirements
- R1: The effective mode is burst only when `fifo_en`=1 and `dma_burst_sel`=1. When `fifo_en`=0, `dma_burst_sel` has no effect and single-transfer behaviour applies.
- R2: While `rst` is high, both `rx_rdy_n` and `tx_rdy_n` are 1 and both burst latches are cleared.
- R3: In single-transfer mode, `rx_rdy_n` is 0 when `rx_level` is nonzero and 1 when it is zero.
- R4: In burst mode, the receive latch is set, and `rx_rdy_n` goes 0, when `rx_trig_hit` or `rx_idle_tmo` is 1 while `rx_level` is nonzero. A nonzero level with neither flag does not set it.
- R5: In burst mode, once the receive latch is set it stays set while `rx_level` is nonzero, even after both flags drop. It clears, and `rx_rdy_n` goes 1, when `rx_level` is zero. A flag that arrives with `rx_level` at zero does not set the latch.
- R6: In single-transfer mode, `tx_rdy_n` is 0 when `tx_level` is zero and 1 when it is nonzero.
- R7: In burst mode, the transmit latch is set when `tx_level` is zero. It stays set (`tx_rdy_n`=0) while the level rises below DEPTH (32) and clears at DEPTH. It then stays clear while the level falls, until the level returns to zero.
- R8: A change of the effective mode discards both burst latches. The outputs on the next clock are evaluated from the current inputs alone, under the new mode.
- R9: Each output reflects the inputs sampled at the previous rising clock edge, with exactly one register of latency.
- R10: After reset is released with `tx_level`=0, `tx_rdy_n` goes 0 at the first rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFO enable control bit |
| dma_burst_sel | input | 1 | Burst DMA mode select control bit |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO or holding-register character count |
| rx_trig_hit | input | 1 | Receive trigger level reached |
| rx_idle_tmo | input | 1 | Receive character timeout |
| tx_level | input | $clog2(DEPTH+1) | Transmit FIFO character count |
| rx_rdy_n | output | 1 | Receive DMA request, active low |
| tx_rdy_n | output | 1 | Transmit DMA request, active low |

## Verification
The bench targets the corner cases that a careless design would get wrong:

- **Hold in burst mode.** The receive request must stay low after the trigger flag drops. A design lacking the hold would release mid-drain.
- **Release at the boundaries.** The transmit request must stay high while the FIFO drains from full. A design that re-armed below full would chatter.
- **Stale latches across mode switches.** The bench switches from burst to single-transfer and back with data still present and no new trigger. A design that kept the latch would assert a request that nothing re-armed.
- **Compatibility mode.** The bench raises the burst select while the FIFOs are disabled. A design that ignored the enable would stop mirroring the count.
- **Random input run.** A long run with random inputs catches off-by-one-cycle timing.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  typedef enum logic {
    DMA_SINGLE = 1'b0,
    DMA_BURST  = 1'b1
  } dma_mode_e;
endpackage

// File: rtl/uart_dma_mode.sv
module uart_dma_mode
  import uart_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fifo_en,
  input  logic      dma_burst_sel,
  output dma_mode_e mode,
  output logic      mode_chg
);
  dma_mode_e mode_q;

  // Burst mode needs the FIFOs; compatibility mode forces single transfer.
  always_comb begin
    mode = DMA_SINGLE;
    if (fifo_en && dma_burst_sel) mode = DMA_BURST;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= DMA_SINGLE;
    else     mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);

  p_compat_single_r1: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> (mode == DMA_SINGLE));
endmodule

// File: rtl/uart_dma_rx_req.sv
module uart_dma_rx_req
  import uart_dma_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  dma_mode_e     mode,
  input  logic          mode_chg,
  input  logic [CW-1:0] rx_level,
  input  logic          rx_trig_hit,
  input  logic          rx_idle_tmo,
  output logic          rx_rdy_n
);
  logic latch_q, latch_d, has_data, rdy_n_d;

  assign has_data = (rx_level != '0);

  always_comb begin
    latch_d = latch_q && !mode_chg;
    if (rx_trig_hit || rx_idle_tmo) latch_d = 1'b1;
    if (!has_data)                  latch_d = 1'b0;
    rdy_n_d = (mode == DMA_BURST) ? !latch_d : !has_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= 1'b0;
      rx_rdy_n <= 1'b1;
    end else begin
      latch_q  <= latch_d;
      rx_rdy_n <= rdy_n_d;
    end
  end

  p_rx_single_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == DMA_SINGLE && rx_level != '0) |=> !rx_rdy_n);
  p_rx_burst_set_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == DMA_BURST && (rx_trig_hit || rx_idle_tmo) && rx_level != '0) |=> !rx_rdy_n);
  p_rx_burst_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == DMA_BURST && rx_level == '0) |=> rx_rdy_n);
endmodule

// File: rtl/uart_dma_tx_req.sv
module uart_dma_tx_req
  import uart_dma_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  dma_mode_e     mode,
  input  logic          mode_chg,
  input  logic [CW-1:0] tx_level,
  output logic          tx_rdy_n
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic latch_q, latch_d, empty, full, rdy_n_d;

  assign empty = (tx_level == '0);
  assign full  = (tx_level >= FULL);

  always_comb begin
    latch_d = latch_q && !mode_chg;
    if (empty) latch_d = 1'b1;
    if (full)  latch_d = 1'b0;
    rdy_n_d = (mode == DMA_BURST) ? !latch_d : !empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= 1'b0;
      tx_rdy_n <= 1'b1;
    end else begin
      latch_q  <= latch_d;
      tx_rdy_n <= rdy_n_d;
    end
  end

  p_tx_single_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == DMA_SINGLE && tx_level != '0) |=> tx_rdy_n);
  p_tx_burst_full_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == DMA_BURST && tx_level == FULL) |=> tx_rdy_n);
  p_tx_burst_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == DMA_BURST && tx_level == '0) |=> !tx_rdy_n);
  p_tx_empty_any_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_level == '0) |=> !tx_rdy_n);
endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
  import uart_dma_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          dma_burst_sel,
  input  logic [CW-1:0] rx_level,
  input  logic          rx_trig_hit,
  input  logic          rx_idle_tmo,
  input  logic [CW-1:0] tx_level,
  output logic          rx_rdy_n,
  output logic          tx_rdy_n
);
  dma_mode_e mode;
  logic      mode_chg;

  uart_dma_mode u_mode (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_burst_sel(dma_burst_sel),
    .mode(mode), .mode_chg(mode_chg)
  );

  uart_dma_rx_req #(.CW(CW)) u_rx (
    .clk(clk), .rst(rst), .mode(mode), .mode_chg(mode_chg),
    .rx_level(rx_level), .rx_trig_hit(rx_trig_hit), .rx_idle_tmo(rx_idle_tmo),
    .rx_rdy_n(rx_rdy_n)
  );

  uart_dma_tx_req #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk(clk), .rst(rst), .mode(mode), .mode_chg(mode_chg),
    .tx_level(tx_level), .tx_rdy_n(tx_rdy_n)
  );

  p_reset_idle_r2: assert property (@(posedge clk)
    rst |=> (rx_rdy_n && tx_rdy_n));
endmodule

// File: tb/uart_dma_ready_bench.sv
module uart_dma_ready_bench;
  localparam int DEPTH = 32;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b0, dma_burst_sel = 1'b0, rx_trig_hit = 1'b0, rx_idle_tmo = 1'b0;
  logic [CW-1:0] rx_level = '0, tx_level = '0;
  logic rx_rdy_n, tx_rdy_n;

  int vectors = 0, miscompares = 0;
  string cur_req = "R2";
  bit done = 1'b0;

  // reference model state
  bit e_rx = 1'b1, e_tx = 1'b1, m_rx_hold = 1'b0, m_tx_hold = 1'b0, m_prev_burst = 1'b0;

  always #2 clk = ~clk;

  uart_dma_ready #(.DEPTH(DEPTH)) u_uart_dma_ready (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_burst_sel(dma_burst_sel),
    .rx_level(rx_level), .rx_trig_hit(rx_trig_hit), .rx_idle_tmo(rx_idle_tmo),
    .tx_level(tx_level), .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
  );

  always @(posedge clk) begin
    if (rst) begin
      e_rx = 1'b1; e_tx = 1'b1; m_rx_hold = 1'b0; m_tx_hold = 1'b0; m_prev_burst = 1'b0;
    end else begin
      bit burst;
      burst = (fifo_en == 1'b1) && (dma_burst_sel == 1'b1);
      if (burst != m_prev_burst) begin m_rx_hold = 1'b0; m_tx_hold = 1'b0; end
      if (int'(rx_level) == 0) m_rx_hold = 1'b0;
      else if (rx_trig_hit || rx_idle_tmo) m_rx_hold = 1'b1;
      if (int'(tx_level) == DEPTH) m_tx_hold = 1'b0;
      else if (int'(tx_level) == 0) m_tx_hold = 1'b1;
      if (burst) begin e_rx = !m_rx_hold; e_tx = !m_tx_hold; end
      else begin e_rx = (int'(rx_level) == 0); e_tx = (int'(tx_level) != 0); end
      m_prev_burst = burst;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (rx_rdy_n !== e_rx) begin
        miscompares++;
        $display("FAIL %s rx_rdy_n actual=%b expected=%b t=%0t", cur_req, rx_rdy_n, e_rx, $time);
      end
      if (tx_rdy_n !== e_tx) begin
        miscompares++;
        $display("FAIL %s tx_rdy_n actual=%b expected=%b t=%0t", cur_req, tx_rdy_n, e_tx, $time);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic drive(input bit fe, input bit bs, input int rxl, input bit tg,
                       input bit to, input int txl);
    fifo_en = fe; dma_burst_sel = bs; rx_level = CW'(rxl);
    rx_trig_hit = tg; rx_idle_tmo = to; tx_level = CW'(txl);
    tick(1);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1;
    cur_req = "R2"; drive(1, 1, 5, 1, 1, 7); tick(2);
    fifo_en = 0; dma_burst_sel = 0; rx_level = '0; rx_trig_hit = 0; rx_idle_tmo = 0; tx_level = '0;
    rst = 1'b0;
    cur_req = "R10"; tick(2);
    cur_req = "R3";
    drive(0, 0, 1, 0, 0, 0); drive(0, 0, 5, 0, 0, 0); drive(0, 0, 0, 0, 0, 0);
    cur_req = "R6";
    drive(0, 0, 0, 0, 0, 1); drive(0, 0, 0, 0, 0, 31); drive(0, 0, 0, 0, 0, 32); drive(0, 0, 0, 0, 0, 0);
    cur_req = "R1";
    drive(0, 1, 3, 0, 0, 4); drive(0, 1, 0, 0, 0, 0); drive(1, 0, 2, 0, 0, 9); drive(1, 0, 0, 0, 0, 0);
    cur_req = "R8"; drive(1, 1, 0, 0, 0, 0); tick(1);
    cur_req = "R4";
    drive(1, 1, 3, 0, 0, 32); drive(1, 1, 8, 1, 0, 32);
    cur_req = "R5";
    drive(1, 1, 5, 0, 0, 32); drive(1, 1, 1, 0, 0, 32); drive(1, 1, 0, 0, 0, 32);
    drive(1, 1, 0, 1, 1, 32); drive(1, 1, 4, 0, 0, 32);
    cur_req = "R4"; drive(1, 1, 2, 0, 1, 32); drive(1, 1, 2, 0, 0, 32);
    cur_req = "R7";
    drive(1, 1, 0, 0, 0, 0); drive(1, 1, 0, 0, 0, 10); drive(1, 1, 0, 0, 0, 31);
    drive(1, 1, 0, 0, 0, 32); drive(1, 1, 0, 0, 0, 20); drive(1, 1, 0, 0, 0, 1);
    drive(1, 1, 0, 0, 0, 0); drive(1, 1, 0, 0, 0, 5);
    cur_req = "R8";
    drive(1, 1, 6, 1, 0, 5); drive(1, 0, 6, 0, 0, 5); drive(1, 1, 6, 0, 0, 5);
    drive(1, 1, 6, 0, 0, 5); drive(0, 1, 6, 0, 0, 5); drive(1, 1, 6, 1, 0, 0);
    cur_req = "R9";
    for (int k = 0; k < 400; k++) begin
      int rl, tl;
      rl = (($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, DEPTH));
      tl = (($urandom_range(0, 3) == 0) ? 0 : (($urandom_range(0, 3) == 0) ? DEPTH : $urandom_range(1, DEPTH)));
      drive(($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0), rl,
            ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) == 0), tl);
    end
    cur_req = "R2"; rst = 1'b1; tick(3);
    finish_run();
  end
endmodule